// File: doc/BRIEF.md
# Nibble-Parallel Transmit Payload Interface

This block takes transmit payload from terminal equipment four bits at a time and turns it into a serial bit stream at the line clock rate. Its only timing reference is the transmit input clock, nominally 34.368 MHz. It divides that clock by four to drive a nibble clock output, nominally 8.592 MHz. The terminal equipment presents a new nibble on each rising edge of the nibble clock. The block samples the 4-bit bus on the third input-clock rising edge after the nibble clock rises. It then shifts the sampled nibble out most significant bit first, one bit per input clock.

The block is slaved to an external frame reference and does not time frames itself. A rising edge on the frame reference passes through a two-stage synchronizer and an edge detector. It then restarts the divide-by-four phase, so that nibble boundaries line up with the start of the outbound frame. A frame is 1536 bits long. If a whole frame goes by with no new reference edge, a sticky flag is raised and serializing carries on.

A small 8-bit operating-mode register holds a mode field and a local loopback request. The loopback request only takes effect in the local-timed serial and nibble-parallel modes. A write that asks for loopback while the mode field selects mode 4 is refused.

Top module: `nib_tx_if`

## Requirements
- R1: While `rst` is high, on each clock edge `reg_q` becomes 0x28 and `nib_clk`, `ser_out`, `frame_sof`, `ref_missing`, `loop_en` and `wr_err` become 0.
- R2: `nib_clk` is a registered divide-by-four of `clk`: high for two cycles, then low for two cycles. Its first rising edge comes on the first clock after reset.
- R3: `nib_in` is sampled on the third rising edge of `clk` after the edge on which `nib_clk` rises. On that same edge `ser_out` takes bit 3 of the sampled nibble.
- R4: Each sampled nibble leaves on `ser_out` in the order bit 3, 2, 1, 0, one bit per clock. Consecutive nibbles follow with no gap.
- R5: `frame_ref` is seen on the clock edges where it is high. Suppose edge n is the first such edge after a low one. Then on edge n+2 the nibble phase restarts: `nib_clk` is high for two cycles from that edge on, and `frame_sof` is high for exactly that one cycle.
- R6: If the restart edge of R5 is also a sampling edge of R3, no nibble is sampled on it. The unsent bits of the previous nibble still go out, then `ser_out` is 0 until the next sampling edge.
- R7: Count the clock edges since the last restart edge, or since reset. If 1536 of them go by with no new restart, `ref_missing` is set and stays at 1 until reset, and counting starts over. A reference period of exactly 1536 clocks never sets the flag.
- R8: In the register, bits [5:3] are the mode field and bit 6 is the loopback request. After a write, `loop_en` is 1 only when bit 6 is 1 and the mode is 2, 3, 5 or 6.
- R9: A write with bit 6 at 1 and mode field 4 stores every other bit as written but stores bit 6 as 0, and sets `wr_err` to 1. Any other write stores the data unchanged and clears `wr_err`.
- R10: `reg_q` shows the stored register value from the clock after the write edge (`reg_we` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit input clock, the only timing reference |
| rst | input | 1 | Synchronous active-high reset |
| nib_in | input | 4 | Payload nibble from the terminal equipment |
| frame_ref | input | 1 | Frame reference; a rising edge starts a frame |
| reg_we | input | 1 | Operating-mode register write strobe |
| reg_wdata | input | 8 | Operating-mode register write data |
| nib_clk | output | 1 | Nibble clock, clk divided by four |
| ser_out | output | 1 | Serialized payload, MSB first |
| frame_sof | output | 1 | One-cycle pulse at each frame restart |
| ref_missing | output | 1 | Sticky: a frame passed without a reference edge |
| reg_q | output | 8 | Operating-mode register contents |
| loop_en | output | 1 | Effective local loopback enable |
| wr_err | output | 1 | Last register write was a refused loopback request |

## Verification
A frame restart and a nibble capture can fall on the same clock edge. That happens when the synchronized reference edge arrives while the phase counter sits just before its sampling value. The bench provokes this by raising `frame_ref` only when its own phase model is at zero, so the restart lands exactly on a sampling edge. It then expects three zero bits on `ser_out` before the next nibble, and its behavioural model checks this cycle by cycle. Reference edges are also placed at the other three phases, so each way a restart can cut into a nibble gets compared.

// File: rtl/nib_tx_pkg.sv
package nib_tx_pkg;
  localparam logic [7:0] MODE_REG_RST = 8'h28;
  localparam int         LOOP_BIT     = 6;
  localparam int         MODE_LSB     = 3;
  localparam int         MODE_W       = 3;
  localparam logic [2:0] MODE_NO_LOOP = 3'd4;

  function automatic logic loop_allowed(input logic [7:0] r);
    logic [2:0] m;
    m = r[MODE_LSB +: MODE_W];
    return r[LOOP_BIT] && (m == 3'd2 || m == 3'd3 || m == 3'd5 || m == 3'd6);
  endfunction
endpackage

// File: rtl/nib_tx_frame_sync.sv
module nib_tx_frame_sync #(
  parameter int NIB_W       = 4,
  parameter int SAMPLE_EDGE = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 1536,
  localparam int PH_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_ref,
  output logic cap,
  output logic nib_clk,
  output logic frame_sof,
  output logic ref_missing
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NIB_W - 1);
  localparam logic [PH_W-1:0]  PH_CAP   = PH_W'(SAMPLE_EDGE - 1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(NIB_W / 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [SYNC_STAGES:0] chain;
  logic                 det;
  logic [PH_W-1:0]      ph, ph_n;
  logic [CNT_W-1:0]     cnt;

  for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) chain[i] <= rst ? 1'b0 : frame_ref;
    end else begin : g_next
      always_ff @(posedge clk) chain[i] <= rst ? 1'b0 : chain[i-1];
    end
  end

  assign det  = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign cap  = (ph == PH_CAP) && !det;
  assign ph_n = det ? '0 : ((ph == PH_LAST) ? '0 : ph + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_LAST;
      nib_clk     <= 1'b0;
      frame_sof   <= 1'b0;
      cnt         <= '0;
      ref_missing <= 1'b0;
    end else begin
      ph        <= ph_n;
      nib_clk   <= (ph_n < PH_HALF);
      frame_sof <= det;
      if (det) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        cnt         <= '0;
        ref_missing <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  nclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_clk) |=> nib_clk);
  // R5
  sof_nclk_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sof |-> nib_clk);
  // R7
  miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ref_missing |=> ref_missing);
endmodule

// File: rtl/nib_tx_serializer.sv
module nib_tx_serializer #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [NIB_W-1:0] nib_in,
  output logic             ser_out
);
  logic [NIB_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      ser_out <= 1'b0;
    end else if (cap) begin
      ser_out <= nib_in[NIB_W-1];
      sh      <= nib_in[NIB_W-2:0];
    end else begin
      ser_out <= sh[NIB_W-2];
      sh      <= {sh[NIB_W-3:0], 1'b0};
    end
  end

  // R6
  drain_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap && $past(!cap) && $past(!cap, 2) && $past(!cap, 3) && !$past(rst, 3)) |=> !ser_out);
endmodule

// File: rtl/nib_tx_mode_reg.sv
module nib_tx_mode_reg
  import nib_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] reg_q,
  output logic       loop_en,
  output logic       wr_err
);
  logic       refuse;
  logic [7:0] nxt;

  always_comb begin
    refuse = wdata[LOOP_BIT] && (wdata[MODE_LSB +: MODE_W] == MODE_NO_LOOP);
    nxt    = wdata;
    if (refuse) nxt[LOOP_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= MODE_REG_RST;
      loop_en <= 1'b0;
      wr_err  <= 1'b0;
    end else if (we) begin
      reg_q   <= nxt;
      loop_en <= loop_allowed(nxt);
      wr_err  <= refuse;
    end
  end

  // R8
  loop_mode_chk: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> (reg_q[LOOP_BIT] && reg_q[MODE_LSB +: MODE_W] != MODE_NO_LOOP));
  // R9
  err_noloop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> (!reg_q[LOOP_BIT] && !loop_en));
endmodule

// File: rtl/nib_tx_if.sv
module nib_tx_if #(
  parameter int NIB_W       = 4,
  parameter int SAMPLE_EDGE = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 1536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib_in,
  input  logic             frame_ref,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic             nib_clk,
  output logic             ser_out,
  output logic             frame_sof,
  output logic             ref_missing,
  output logic [7:0]       reg_q,
  output logic             loop_en,
  output logic             wr_err
);
  logic cap;

  nib_tx_frame_sync #(
    .NIB_W(NIB_W), .SAMPLE_EDGE(SAMPLE_EDGE),
    .SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS)
  ) u_sync (
    .clk(clk), .rst(rst), .frame_ref(frame_ref), .cap(cap),
    .nib_clk(nib_clk), .frame_sof(frame_sof), .ref_missing(ref_missing)
  );

  nib_tx_serializer #(.NIB_W(NIB_W)) u_ser (
    .clk(clk), .rst(rst), .cap(cap), .nib_in(nib_in), .ser_out(ser_out)
  );

  nib_tx_mode_reg u_mode (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .reg_q(reg_q), .loop_en(loop_en), .wr_err(wr_err)
  );
endmodule

// File: tb/nib_tx_if_test.sv
`timescale 1ns/1ps
module nib_tx_if_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nib_in = 4'h0;
  logic       frame_ref = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       nib_clk, ser_out, frame_sof, ref_missing, loop_en, wr_err;
  logic [7:0] reg_q;

  always #2.5 clk = ~clk;

  nib_tx_if uut (
    .clk(clk), .rst(rst), .nib_in(nib_in), .frame_ref(frame_ref),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .nib_clk(nib_clk),
    .ser_out(ser_out), .frame_sof(frame_sof), .ref_missing(ref_missing),
    .reg_q(reg_q), .loop_en(loop_en), .wr_err(wr_err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int   cyc = 0;
  int   m_ph = 3;
  bit   m_nclk, m_ser, m_sof, m_miss, m_loop, m_err;
  bit   m_q[$];
  int   fire_q[$];
  bit   fr_last;
  int   m_last = 0;
  logic [7:0] m_reg = 8'h28;
  bit   ev, capt;
  int   md;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 3; m_nclk = 0; m_ser = 0; m_sof = 0; m_miss = 0;
      m_q.delete(); fire_q.delete(); fr_last = 0; m_last = cyc;
      m_reg = 8'h28; m_loop = 0; m_err = 0;
    end else begin
      ev = (fire_q.size() > 0 && fire_q[0] == cyc);
      if (ev) void'(fire_q.pop_front());
      if (frame_ref && !fr_last) fire_q.push_back(cyc + 2);
      fr_last = frame_ref;
      capt = (m_ph == 2) && !ev;
      if (capt) begin
        m_ser = nib_in[3];
        m_q.delete();
        m_q.push_back(nib_in[2]); m_q.push_back(nib_in[1]); m_q.push_back(nib_in[0]);
      end else begin
        m_ser = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
      end
      m_ph   = ev ? 0 : (m_ph + 1) % 4;
      m_nclk = (m_ph < 2);
      m_sof  = ev;
      if (ev) m_last = cyc;
      else if (cyc - m_last == 1536) begin m_miss = 1; m_last = cyc; end
      if (reg_we) begin
        md = reg_wdata[5:3];
        if (reg_wdata[6] && md == 4) begin
          m_reg = reg_wdata & 8'hBF; m_err = 1; m_loop = 0;
        end else begin
          m_reg = reg_wdata; m_err = 0;
          m_loop = reg_wdata[6] && (md == 2 || md == 3 || md == 5 || md == 6);
        end
      end
    end
  end

  always @(negedge clk) begin
    chk("R2", "nib_clk", nib_clk, m_nclk);
    chk("R3/R4", "ser_out", ser_out, m_ser);
    chk("R5", "frame_sof", frame_sof, m_sof);
    chk("R7", "ref_missing", ref_missing, m_miss);
    chk("R10", "reg_q", reg_q, m_reg);
    chk("R8", "loop_en", loop_en, m_loop);
    chk("R9", "wr_err", wr_err, m_err);
  end

  // terminal equipment: new nibble on each nib_clk rise, or every cycle in random mode
  bit         rand_mode = 0;
  bit         nclk_prev = 0;
  logic [7:0] lfsr = 8'h5A;
  always @(negedge clk) begin
    if (rand_mode || (nib_clk && !nclk_prev)) begin
      lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      nib_in = lfsr[3:0];
    end
    nclk_prev = nib_clk;
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_chk();
    frame_ref = 1'b1;
    waitn(3);
    chk("R5", "sof after sync", frame_sof, 1);
    chk("R5", "nib_clk at restart", nib_clk, 1);
    frame_ref = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] exp_q, input bit exp_loop, input bit exp_err);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10", "reg_q readback", reg_q, exp_q);
    chk("R8", "loop_en", loop_en, exp_loop);
    chk("R9", "wr_err", wr_err, exp_err);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    waitn(4);
    chk("R1", "reg_q reset", reg_q, 8'h28);
    chk("R1", "nib_clk reset", nib_clk, 0);
    chk("R1", "ser_out reset", ser_out, 0);
    chk("R1", "flags reset", {frame_sof, ref_missing, loop_en, wr_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "first nib_clk rise", nib_clk, 1);
    waitn(2);
    chk("R2", "nib_clk low phase", nib_clk, 0);
    waitn(10);
    // frames exactly 1536 clocks apart
    pulse_chk();
    waitn(1533);
    pulse_chk();
    waitn(1533);
    pulse_chk();
    chk("R7", "no flag at exact period", ref_missing, 0);
    // restart landing on a sampling edge
    waitn(1200);
    while (m_ph != 0) @(negedge clk);
    pulse_chk();
    chk("R6", "drain bit 0", ser_out, 0);
    waitn(1);
    chk("R6", "drain bit 1", ser_out, 0);
    waitn(1);
    chk("R6", "drain bit 2", ser_out, 0);
    // random payload, restarts at other phases
    rand_mode = 1;
    for (int p = 1; p < 4; p++) begin
      waitn(900);
      while (m_ph != p) @(negedge clk);
      pulse_chk();
    end
    // register behaviour
    wr(8'h68, 8'h68, 1, 0);
    wr(8'h60, 8'h20, 0, 1);
    wr(8'h50, 8'h50, 1, 0);
    wr(8'hE7, 8'hA7, 0, 1);
    wr(8'h70, 8'h70, 1, 0);
    wr(8'h58, 8'h58, 1, 0);
    wr(8'h40, 8'h40, 0, 0);
    wr(8'h78, 8'h78, 0, 0);
    wr(8'h28, 8'h28, 0, 0);
    // missing reference
    waitn(500);
    pulse_chk();
    waitn(1535);
    chk("R7", "flag before boundary", ref_missing, 0);
    waitn(1);
    chk("R7", "flag at boundary", ref_missing, 1);
    waitn(2000);
    chk("R7", "flag sticky", ref_missing, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule